// File: doc/BRIEF.md
# Synchronous Burst SRAM with Lane Writes

This block is a small synchronous static memory for use inside a larger chip. Every control and data input is sampled on the rising clock edge. The word is made of four 9-bit byte lanes. A two-bit counter supplies the address of each beat of a four-beat burst. The counter can step in linear order or in interleaved order.

A burst starts on either of two start strobes. The processor-side start always begins with a read. The controller-side start obeys the write controls. After the start, the advance strobe steps the counter. A new address may also be loaded on every cycle with no burst at all.

Writes can be global, covering every lane, or limited to selected lanes. A mode input selects how reads reach the output: in flow-through mode the data comes straight from the array, and in pipelined mode it passes through an extra output register. Output drive follows single-cycle deselect timing. An asynchronous output enable gates the drive, and a sleep input freezes all activity while keeping the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle with `ce` high and either start strobe high loads `addr` and accesses that address, and it restarts the beat counter at zero. A start strobe with `ce` low performs no access and no write.
- R2: With `order_sel` low, each cycle with `adv` high and no start strobe accesses the next beat n = 1, 2, 3. The two low address bits of that beat are (start low bits + n) mod 4, and the upper bits stay equal to those of the loaded address.
- R3: With `order_sel` high, the low address bits of beat n are (start low bits) XOR n.
- R4: The beat counter wraps around. The fourth advance after a start accesses the start address again.
- R5: When `gw` is high on a write-capable access, every lane is written from `din`, whatever the values of `bw_en` and `lane_we`. Lane i uses bits [9i+8:9i].
- R6: When `gw` is low, a write happens only if `bw_en` is high and at least one bit of `lane_we` is high. Only lanes with `lane_we[i]` high change. Otherwise the access is a read.
- R7: An access started by `start_p` is always a read, even when `start_c` or the write controls are also high. An access started by `start_c` alone follows R5 and R6.
- R8: When a start strobe and `adv` are high in the same cycle, the load wins. The next `adv` then accesses beat 1 of the new address.
- R9: With `pipe_mode` low, a read captured at edge k drives its data on `dout`, with `dout_oe` high, right after edge k.
- R10: With `pipe_mode` high, a read captured at edge k drives its data right after edge k+1, one cycle later than in flow-through mode.
- R11: Each read drives the output for exactly one cycle. When a cycle captures a deselect or a write, `dout_oe` is low after that edge in flow-through mode, or one edge later in pipelined mode.
- R12: While `oe` is low, `dout_oe` is low and `dout` is zero. Raising `oe` drives the pending read data with no clock edge.
- R13: While `sleep` is high, no read or write is performed, the burst position is held, `dout_oe` is low, and the stored contents are kept.
- R14: After reset, `dout_oe` is low and the burst position is address zero, beat zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | External word address |
| din | input | LANES*LANE_W | Write data, lane i in bits [9i+8:9i] |
| ce | input | 1 | Chip enable, qualifies start strobes |
| start_p | input | 1 | Processor-side burst start (always read) |
| start_c | input | 1 | Controller-side burst start |
| adv | input | 1 | Burst advance |
| lane_we | input | LANES | Per-lane write enables |
| bw_en | input | 1 | Lane-write enable |
| gw | input | 1 | Global write |
| order_sel | input | 1 | 0 linear, 1 interleaved burst order |
| pipe_mode | input | 1 | 0 flow-through, 1 pipelined read |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Freeze accesses, keep contents |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_oe | output | 1 | Output drive enable for the pad |

## Verification
Bursts from a start address whose low bits are 1 are run in both orders. The two orders give different beat sequences (5,6,7,4 against 5,4,7,6), so swapping the orders, or breaking the wrap, shows up as a wrong word. Lane writes use a mask with alternating lanes over known background data, so a shifted or inverted lane mapping is visible. Global writes run with `bw_en` low, and the other write-control combinations are applied to addresses that are then read back unchanged. Single reads, back-to-back reads and reads followed by deselects are run in both output modes. This separates flow-through latency from pipelined latency and shows whether the drive window ends one cycle after the last read.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sbs_cmd_e;

  // low two address bits for a given beat of a burst
  function automatic logic [1:0] beat_low_bits(input logic [1:0] start_lo,
                                               input logic [1:0] beat,
                                               input logic       ileave);
    logic [1:0] r;
    if (ileave) r = start_lo ^ beat;
    else        r = start_lo + beat;
    return r;
  endfunction

endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              ileave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  import sbs_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nxt;

  assign cnt_nxt  = cnt_q + 2'd1;
  assign acc_addr = load ? ext_addr
                         : {base_q[ADDR_W-1:2], beat_low_bits(base_q[1:0], cnt_nxt, ileave)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
    end
  end

  // R8
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0) && (base_q == $past(ext_addr)));

  // R4
  beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == 2'd3) |=> cnt_q == 2'd0);

  // R13
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q) && $stable(base_q));

endmodule

// File: rtl/sbs_lane_write.sv
module sbs_lane_write #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic             gw,
  input  logic             bw_en,
  input  logic [LANES-1:0] lane_we,
  output logic [LANES-1:0] we_mask
);

  function automatic logic [LANES-1:0] lanes_to_write(input logic g,
                                                      input logic b,
                                                      input logic [LANES-1:0] sel);
    logic [LANES-1:0] m;
    if (g)      m = '1;
    else if (b) m = sel;
    else        m = '0;
    return m;
  endfunction

  assign we_mask = allow ? lanes_to_write(gw, bw_en, lane_we) : '0;

  // R5
  global_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && gw) |-> (&we_mask));

  // R6
  lane_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gw |-> ((we_mask & ~lane_we) == '0));

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
      if (we_mask[g]) arr[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = arr[rd_addr];
  end

endmodule

// File: rtl/sbs_read_stage.sv
module sbs_read_stage #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              sleep,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  logic [ADDR_W-1:0] ra_q;
  logic              rv_q;
  logic              pv_q;
  logic [DATA_W-1:0] pd_q;
  logic              stage_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
      rv_q <= 1'b0;
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      if (rd_fire) ra_q <= rd_addr;
      rv_q <= rd_fire;
      pv_q <= rv_q;
      pd_q <= mem_rdata;
    end
  end

  assign mem_raddr  = ra_q;
  assign stage_live = pipe_mode ? pv_q : rv_q;
  assign dout_oe    = oe && !sleep && stage_live;
  assign dout       = dout_oe ? (pipe_mode ? pd_q : mem_rdata) : '0;

  // R9
  flow_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && oe && !sleep && $past(rd_fire)) |-> dout_oe);

  // R10
  pipe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && oe && !sleep && $past(rd_fire, 2)) |-> dout_oe);

  // R11
  flow_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !$past(rd_fire)) |-> !dout_oe);

  // R11
  pipe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !$past(rd_fire, 2)) |-> !dout_oe);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce,
  input  logic              start_p,
  input  logic              start_c,
  input  logic              adv,
  input  logic [LANES-1:0]  lane_we,
  input  logic              bw_en,
  input  logic              gw,
  input  logic              order_sel,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  import sbs_pkg::*;

  logic              any_start;
  logic              load_ev;
  logic              step_ev;
  logic              wr_req;
  sbs_cmd_e          cmd;
  logic              rd_fire;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  we_mask;
  logic [ADDR_W-1:0] mem_raddr;
  logic [DATA_W-1:0] mem_rdata;

  assign any_start = start_p || start_c;
  assign load_ev   = !sleep && ce && any_start;
  assign step_ev   = !sleep && !any_start && adv;
  assign wr_req    = gw || (bw_en && (|lane_we));

  always_comb begin
    if (!(load_ev || step_ev))            cmd = CMD_NONE;
    else if (load_ev && start_p)          cmd = CMD_READ;
    else if (wr_req)                      cmd = CMD_WRITE;
    else                                  cmd = CMD_READ;
  end

  assign rd_fire = (cmd == CMD_READ);

  sbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ev),
    .step     (step_ev),
    .ileave   (order_sel),
    .ext_addr (addr),
    .acc_addr (acc_addr)
  );

  sbs_lane_write #(.LANES(LANES)) u_lwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .allow   (cmd == CMD_WRITE),
    .gw      (gw),
    .bw_en   (bw_en),
    .lane_we (lane_we),
    .we_mask (we_mask)
  );

  sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .we_mask (we_mask),
    .wr_addr (acc_addr),
    .wdata   (din),
    .rd_addr (mem_raddr),
    .rdata   (mem_rdata)
  );

  sbs_read_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rd_addr   (acc_addr),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .sleep     (sleep),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  // R13
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (we_mask == '0) && !rd_fire);

  // R7
  pstart_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && start_p) |-> (we_mask == '0));

  // R1
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && any_start) |-> (we_mask == '0) && !rd_fire);

  // R12
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dout_oe && (dout == '0));

endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ce = 1'b1, start_p = 1'b0, start_c = 1'b0, adv = 1'b0;
  logic [3:0] lane_we = '0;
  logic bw_en = 1'b0, gw = 1'b0, order_sel = 1'b0, pipe_mode = 1'b0;
  logic oe = 1'b1, sleep = 1'b0;
  logic [DW-1:0] dout;
  logic dout_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce(ce),
    .start_p(start_p), .start_c(start_c), .adv(adv), .lane_we(lane_we),
    .bw_en(bw_en), .gw(gw), .order_sel(order_sel), .pipe_mode(pipe_mode),
    .oe(oe), .sleep(sleep), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return (36'(a) * 36'h0_0101_0103) ^ 36'h5_A5A5_A5A5;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // drive one cycle of inputs, step past the edge, settle
  task automatic op(input logic sp, input logic sc, input logic av, input logic e,
                    input logic g, input logic b, input logic [3:0] we,
                    input int a, input logic [DW-1:0] d);
    start_p = sp; start_c = sc; adv = av; ce = e; gw = g; bw_en = b;
    lane_we = we; addr = AW'(a); din = d;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    op(0, 0, 0, 1, 0, 0, 4'h0, 0, '0);
  endtask

  task automatic see(input string tag, input int a);
    chk({tag, " oe"}, {35'd0, dout_oe}, 36'd1);
    chk({tag, " data"}, dout, exp_mem[a]);
  endtask

  task automatic t_reset();
    chk("R14 reset drive", {35'd0, dout_oe}, 36'd0);
    // adv from reset steps beat 1 of address 0 -> address 1
    op(0, 0, 1, 1, 0, 0, 4'h0, 0, '0);
    see("R14 reset burst base", 1);
    idle();
  endtask

  task automatic t_fill();
    for (int a = 0; a < 16; a++) begin
      op(0, 1, 0, 1, 1, 0, 4'h0, a, pat(a));
      exp_mem[a] = pat(a);
    end
    idle();
  endtask

  task automatic t_flow_read();
    pipe_mode = 0;
    op(1, 0, 0, 1, 0, 0, 4'h0, 5, '0);
    see("R9 R1 flow read", 5);
    op(0, 1, 0, 1, 0, 0, 4'h0, 9, '0);
    see("R1 back-to-back load", 9);
    idle();
    chk("R11 flow deselect", {35'd0, dout_oe}, 36'd0);
  endtask

  task automatic t_burst(input logic ord, input string tag);
    int seq[5];
    order_sel = ord;
    if (!ord) seq = '{5, 6, 7, 4, 5};
    else      seq = '{5, 4, 7, 6, 5};
    op(1, 0, 0, 1, 0, 0, 4'h0, 5, '0);
    see({tag, " beat0"}, seq[0]);
    for (int i = 1; i < 5; i++) begin
      op(0, 0, 1, 1, 0, 0, 4'h0, 0, '0);
      see((i == 4) ? "R4 wrap" : tag, seq[i]);
    end
    idle();
    order_sel = 0;
  endtask

  task automatic t_pipe();
    pipe_mode = 1;
    idle();
    op(1, 0, 0, 1, 0, 0, 4'h0, 9, '0);
    chk("R10 not yet driven", {35'd0, dout_oe}, 36'd0);
    idle();
    see("R10 pipe read", 9);
    idle();
    chk("R11 pipe release", {35'd0, dout_oe}, 36'd0);
    op(1, 0, 0, 1, 0, 0, 4'h0, 10, '0);
    op(1, 0, 0, 1, 0, 0, 4'h0, 11, '0);
    see("R10 stream 10", 10);
    op(0, 1, 0, 1, 1, 0, 4'h0, 12, pat(12));
    see("R10 stream 11", 11);
    idle();
    chk("R11 write releases", {35'd0, dout_oe}, 36'd0);
    pipe_mode = 0;
    idle();
  endtask

  task automatic t_lane_write();
    logic [DW-1:0] nv, m;
    nv = 36'h1_2345_6789;
    op(0, 1, 0, 1, 0, 1, 4'b0101, 3, nv);
    m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    exp_mem[3] = (nv & m) | (exp_mem[3] & ~m);
    chk("R11 write no drive", {35'd0, dout_oe}, 36'd0);
    // lane enables without bw_en: must act as a read
    op(0, 1, 0, 1, 0, 0, 4'hF, 4, 36'h0_0000_0000);
    see("R6 no bw_en reads", 4);
    // global write with bw_en and lanes low
    op(0, 1, 0, 1, 1, 0, 4'h0, 8, 36'hF_0F0F_0F0F);
    exp_mem[8] = 36'hF_0F0F_0F0F;
    op(1, 0, 0, 1, 0, 0, 4'h0, 3, '0);
    see("R6 lane mask", 3);
    op(1, 0, 0, 1, 0, 0, 4'h0, 8, '0);
    see("R5 global write", 8);
    op(1, 0, 0, 1, 0, 0, 4'h0, 4, '0);
    see("R6 unchanged", 4);
    idle();
  endtask

  task automatic t_pstart();
    op(1, 1, 0, 1, 1, 1, 4'hF, 2, 36'h0);
    see("R7 both starts read", 2);
    op(1, 0, 0, 1, 1, 0, 4'h0, 2, 36'h0);
    see("R7 pstart read", 2);
    op(1, 0, 0, 1, 0, 0, 4'h0, 2, '0);
    see("R7 contents kept", 2);
    idle();
  endtask

  task automatic t_priority();
    op(1, 0, 0, 1, 0, 0, 4'h0, 5, '0);
    op(0, 0, 1, 1, 0, 0, 4'h0, 0, '0);
    see("R8 pre", 6);
    op(0, 1, 1, 1, 0, 0, 4'h0, 12, '0);
    see("R8 load wins", 12);
    op(0, 0, 1, 1, 0, 0, 4'h0, 0, '0);
    see("R8 beat1 of new", 13);
    idle();
  endtask

  task automatic t_oe();
    oe = 0;
    op(1, 0, 0, 1, 0, 0, 4'h0, 7, '0);
    chk("R12 oe low drive", {35'd0, dout_oe}, 36'd0);
    chk("R12 oe low data", dout, 36'd0);
    oe = 1; #1;
    see("R12 oe async", 7);
    idle();
  endtask

  task automatic t_sleep();
    op(1, 0, 0, 1, 0, 0, 4'h0, 5, '0);
    op(0, 0, 1, 1, 0, 0, 4'h0, 0, '0);
    sleep = 1; #1;
    chk("R13 sleep drive", {35'd0, dout_oe}, 36'd0);
    op(0, 0, 1, 1, 0, 0, 4'h0, 0, '0);
    op(0, 1, 0, 1, 1, 0, 4'h0, 1, 36'h0);
    sleep = 0;
    op(0, 0, 1, 1, 0, 0, 4'h0, 0, '0);
    see("R13 burst held", 7);
    op(1, 0, 0, 1, 0, 0, 4'h0, 1, '0);
    see("R13 contents kept", 1);
    idle();
  endtask

  task automatic t_ce();
    op(0, 1, 0, 0, 1, 0, 4'h0, 0, 36'h0);
    chk("R1 ce low no drive", {35'd0, dout_oe}, 36'd0);
    op(1, 0, 0, 1, 0, 0, 4'h0, 0, '0);
    see("R1 ce low no write", 0);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R14 drive in reset", {35'd0, dout_oe}, 36'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_fill();
    t_flow_read();
    t_burst(0, "R2 linear");
    t_burst(1, "R3 interleaved");
    t_pipe();
    t_lane_write();
    t_pstart();
    t_priority();
    t_oe();
    t_sleep();
    t_ce();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule